// File: doc/BRIEF.md
# Four-Profile Oscillator Parameter Bank

This block keeps four identical sets of modulator control parameters and feeds one set, the active profile, to the rest of the datapath. Each set holds a 32-bit frequency tuning word, a spectral-invert flag, an inverse-CIC bypass flag, a CIC interpolation rate and an output gain. Software loads any set at any time through a small write port that takes a profile index, a field code and data. Two external select pins choose the active set.

The select pins are captured on a clock that depends on the operating mode. In single-tone mode they are captured on every system-clock cycle. In quadrature-modulation and interpolating-DAC modes they are captured only on cycles that carry the data-clock sample strobe. The block also contains the numerically controlled oscillator phase accumulator. The accumulator advances by the active tuning word on every cycle, and a zero tuning word parks it at phase zero.

Top module: `dds_profile_bank`

## Requirements
- R1: After reset every stored field of every profile is zero, profile 0 is active and the phase is 0. A zero stored rate means `cic_byp_o` reads 1.
- R2: Writes use `wr_field_i` codes 0 (tuning word, data[31:0]), 1 (flags: data[0] spectral invert, data[1] inverse-CIC bypass), 2 (CIC rate, data[5:0]) and 3 (gain, data[7:0]). A write to one profile leaves the other three unchanged.
- R3: The active profile index is `{sel_i[1], sel_i[0]}`, so 00, 01, 10 and 11 pick profiles 0, 1, 2 and 3. The outputs show the fields of the newly selected profile from the cycle after the capturing edge.
- R4: When `mode_i` is 1 (single tone), the pins are captured at every clock edge. When `mode_i` is 0 (quadrature), 2 (interpolating DAC) or 3 (treated like 2), the pins are captured only at edges where `samp_stb_i` is 1.
- R5: `spec_inv_o` equals the active profile's invert flag only when `mode_i` is 0. In every other mode it is 0.
- R6: A stored CIC rate of 0 is the bypass code, and `cic_byp_o` is 1 for it. Rates from 1 to 63 are stored and shown unchanged, with `cic_byp_o` equal to 0.
- R7: The gain is an 8-bit unsigned value with 1 integer bit and 7 fraction bits (0 to 1.9921875). It is stored and shown unchanged.
- R8: When the active tuning word is nonzero, each clock edge adds it to the phase, modulo 2^32.
- R9: When the active tuning word is zero, the phase is 0 after the next clock edge, which gives sine 0 and cosine 1 downstream.
- R10: A profile change does not reset the phase. The new tuning word is first added at the edge after the capturing edge.
- R11: Writes with field codes 4 to 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_prof_i | input | 2 | Profile written |
| wr_field_i | input | 3 | Field code |
| wr_data_i | input | 32 | Write data |
| sel_i | input | 2 | Profile select pins, bit 1 is the upper pin |
| mode_i | input | 2 | 0 quadrature, 1 single tone, 2/3 interpolating DAC |
| samp_stb_i | input | 1 | Data-clock sample strobe |
| act_prof_o | output | 2 | Active profile index |
| ftw_o | output | 32 | Active tuning word |
| spec_inv_o | output | 1 | Effective spectral invert |
| icic_byp_o | output | 1 | Inverse-CIC bypass |
| cic_rate_o | output | 6 | CIC interpolation rate |
| cic_byp_o | output | 1 | CIC bypass (rate code 0) |
| scale_o | output | 8 | Output gain, 1.7 format |
| phase_o | output | 32 | Accumulator phase |

## Verification
The bench builds the block with its default parameters: four profiles, a 32-bit tuning word and phase, a 6-bit rate and an 8-bit gain. With these values every profile index, the full 1-to-63 rate range with its bypass code, the gain's top code and phase wraparound can all be reached. Wraparound is driven quickly by tuning words close to 2^32. A directed phase then checks select capture under each mode and strobe combination with exact phase values, and random traffic follows with writes that include the unused field codes.

// File: rtl/dds_prof_pkg.sv
package dds_prof_pkg;
  localparam int unsigned NPROF_DEF = 4;
  localparam int unsigned FTW_W_DEF = 32;
  localparam int unsigned RATE_W_DEF = 6;
  localparam int unsigned SCALE_W_DEF = 8;
  localparam int unsigned FLD_W = 3;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_TONE = 2'd1,
    MODE_IDAC = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [FLD_W-1:0] {
    FLD_FTW   = 3'd0,
    FLD_FLAGS = 3'd1,
    FLD_RATE  = 3'd2,
    FLD_SCALE = 3'd3
  } field_e;
endpackage

// File: rtl/prof_regs.sv
module prof_regs
  import dds_prof_pkg::*;
#(
  parameter int unsigned NPROF   = NPROF_DEF,
  parameter int unsigned FTW_W   = FTW_W_DEF,
  parameter int unsigned RATE_W  = RATE_W_DEF,
  parameter int unsigned SCALE_W = SCALE_W_DEF,
  localparam int unsigned PW     = $clog2(NPROF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PW-1:0]      wr_prof_i,
  input  logic [FLD_W-1:0]   wr_field_i,
  input  logic [FTW_W-1:0]   wr_data_i,
  input  logic [PW-1:0]      rd_prof_i,
  output logic [FTW_W-1:0]   rd_ftw_o,
  output logic               rd_inv_o,
  output logic               rd_icb_o,
  output logic [RATE_W-1:0]  rd_rate_o,
  output logic [SCALE_W-1:0] rd_scale_o
);
  logic [FTW_W-1:0]   ftw_q   [NPROF];
  logic               inv_q   [NPROF];
  logic               icb_q   [NPROF];
  logic [RATE_W-1:0]  rate_q  [NPROF];
  logic [SCALE_W-1:0] scale_q [NPROF];

  for (genvar p = 0; p < NPROF; p++) begin : g_prof
    logic hit;
    assign hit = wr_en_i && (wr_prof_i == PW'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ftw_q[p]   <= '0;
        inv_q[p]   <= 1'b0;
        icb_q[p]   <= 1'b0;
        rate_q[p]  <= '0;
        scale_q[p] <= '0;
      end else if (hit) begin
        unique case (wr_field_i)
          FLD_FTW:   ftw_q[p] <= wr_data_i;
          FLD_FLAGS: begin
            inv_q[p] <= wr_data_i[0];
            icb_q[p] <= wr_data_i[1];
          end
          FLD_RATE:  rate_q[p]  <= wr_data_i[RATE_W-1:0];  // 0 = bypass code
          FLD_SCALE: scale_q[p] <= wr_data_i[SCALE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign rd_ftw_o   = ftw_q[rd_prof_i];
  assign rd_inv_o   = inv_q[rd_prof_i];
  assign rd_icb_o   = icb_q[rd_prof_i];
  assign rd_rate_o  = rate_q[rd_prof_i];
  assign rd_scale_o = scale_q[rd_prof_i];
endmodule

// File: rtl/prof_select.sv
module prof_select
  import dds_prof_pkg::*;
#(
  parameter int unsigned NPROF = NPROF_DEF,
  localparam int unsigned PW   = $clog2(NPROF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          samp_stb_i,
  input  logic [PW-1:0] pins_i,
  output logic [PW-1:0] prof_o
);
  logic take;
  // single tone samples on system clock, other modes on the data-clock strobe
  assign take = (mode_i == MODE_TONE) || samp_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prof_o <= '0;
    else if (take) prof_o <= pins_i;
  end
endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ftw_i,
  output logic [W-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_o <= '0;
    else if (ftw_i == '0)     phase_o <= '0;  // zero-phase park
    else                      phase_o <= phase_o + ftw_i;
  end
endmodule

// File: rtl/dds_profile_bank.sv
module dds_profile_bank
  import dds_prof_pkg::*;
#(
  parameter int unsigned NPROF   = NPROF_DEF,
  parameter int unsigned FTW_W   = FTW_W_DEF,
  parameter int unsigned RATE_W  = RATE_W_DEF,
  parameter int unsigned SCALE_W = SCALE_W_DEF,
  localparam int unsigned PW     = $clog2(NPROF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [PW-1:0]      wr_prof_i,
  input  logic [FLD_W-1:0]   wr_field_i,
  input  logic [FTW_W-1:0]   wr_data_i,
  input  logic [PW-1:0]      sel_i,
  input  logic [1:0]         mode_i,
  input  logic               samp_stb_i,
  output logic [PW-1:0]      act_prof_o,
  output logic [FTW_W-1:0]   ftw_o,
  output logic               spec_inv_o,
  output logic               icic_byp_o,
  output logic [RATE_W-1:0]  cic_rate_o,
  output logic               cic_byp_o,
  output logic [SCALE_W-1:0] scale_o,
  output logic [FTW_W-1:0]   phase_o
);
  logic inv_raw;

  prof_select #(.NPROF(NPROF)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .samp_stb_i (samp_stb_i),
    .pins_i     (sel_i),
    .prof_o     (act_prof_o)
  );

  prof_regs #(
    .NPROF(NPROF), .FTW_W(FTW_W), .RATE_W(RATE_W), .SCALE_W(SCALE_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_prof_i  (wr_prof_i),
    .wr_field_i (wr_field_i),
    .wr_data_i  (wr_data_i),
    .rd_prof_i  (act_prof_o),
    .rd_ftw_o   (ftw_o),
    .rd_inv_o   (inv_raw),
    .rd_icb_o   (icic_byp_o),
    .rd_rate_o  (cic_rate_o),
    .rd_scale_o (scale_o)
  );

  phase_acc #(.W(FTW_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ftw_i   (ftw_o),
    .phase_o (phase_o)
  );

  assign spec_inv_o = inv_raw && (mode_i == MODE_QUAD);
  assign cic_byp_o  = (cic_rate_o == '0);
endmodule

// File: rtl/dds_profile_bank_chk.sv
module dds_profile_bank_chk
  import dds_prof_pkg::*;
#(
  parameter int unsigned NPROF   = NPROF_DEF,
  parameter int unsigned FTW_W   = FTW_W_DEF,
  parameter int unsigned RATE_W  = RATE_W_DEF,
  parameter int unsigned SCALE_W = SCALE_W_DEF,
  localparam int unsigned PW     = $clog2(NPROF)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [PW-1:0]      wr_prof_i,
  input logic [FLD_W-1:0]   wr_field_i,
  input logic [FTW_W-1:0]   wr_data_i,
  input logic [PW-1:0]      sel_i,
  input logic [1:0]         mode_i,
  input logic               samp_stb_i,
  input logic [PW-1:0]      act_prof_o,
  input logic [FTW_W-1:0]   ftw_o,
  input logic               spec_inv_o,
  input logic               icic_byp_o,
  input logic [RATE_W-1:0]  cic_rate_o,
  input logic               cic_byp_o,
  input logic [SCALE_W-1:0] scale_o,
  input logic [FTW_W-1:0]   phase_o
);
  p_zero_park_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ftw_o == '0) |=> (phase_o == '0));

  p_acc_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ftw_o != '0) |=> (phase_o == FTW_W'($past(phase_o) + $past(ftw_o))));

  p_inv_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_QUAD) |-> !spec_inv_o);

  p_tone_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TONE) |=> (act_prof_o == $past(sel_i)));

  p_hold_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_TONE && !samp_stb_i) |=> $stable(act_prof_o));

  p_rate_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_field_i == FLD_RATE && wr_prof_i == act_prof_o &&
     mode_i != MODE_TONE && !samp_stb_i)
    |=> (cic_rate_o == $past(wr_data_i[RATE_W-1:0])) &&
        (cic_byp_o == ($past(wr_data_i[RATE_W-1:0]) == '0)));
endmodule

bind dds_profile_bank dds_profile_bank_chk #(
  .NPROF(NPROF), .FTW_W(FTW_W), .RATE_W(RATE_W), .SCALE_W(SCALE_W)
) u_chk (.*);

// File: tb/sim_dds_profile_bank.sv
`timescale 1ns/1ps
module sim_dds_profile_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_prof = '0;
  logic [2:0]  wr_field = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  sel = '0;
  logic [1:0]  mode = 2'd1;
  logic        stb = 1'b0;
  logic [1:0]  act_prof;
  logic [31:0] ftw, phase;
  logic        inv, icb, cbyp;
  logic [5:0]  rate;
  logic [7:0]  scale;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [31:0] m_ftw [4];
  logic        m_inv [4];
  logic        m_icb [4];
  logic [5:0]  m_rate [4];
  logic [7:0]  m_scale [4];
  logic [1:0]  m_sel;
  logic [31:0] m_phase;

  always #2.5 clk = ~clk;

  dds_profile_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_prof_i(wr_prof),
    .wr_field_i(wr_field), .wr_data_i(wr_data), .sel_i(sel), .mode_i(mode),
    .samp_stb_i(stb), .act_prof_o(act_prof), .ftw_o(ftw), .spec_inv_o(inv),
    .icic_byp_o(icb), .cic_rate_o(rate), .cic_byp_o(cbyp), .scale_o(scale),
    .phase_o(phase)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < 4; p++) begin
      m_ftw[p] = '0; m_inv[p] = 0; m_icb[p] = 0; m_rate[p] = '0; m_scale[p] = '0;
    end
    m_sel = '0; m_phase = '0;
  endtask

  task automatic model_edge();
    logic [31:0] a;
    a = m_ftw[m_sel];
    m_phase = (a == 0) ? 32'd0 : m_phase + a;
    if (wr_en) begin
      case (wr_field)
        3'd0: m_ftw[wr_prof] = wr_data;
        3'd1: begin m_inv[wr_prof] = wr_data[0]; m_icb[wr_prof] = wr_data[1]; end
        3'd2: m_rate[wr_prof] = wr_data[5:0];
        3'd3: m_scale[wr_prof] = wr_data[7:0];
        default: ;
      endcase
    end
    if (mode == 2'd1 || stb) m_sel = sel;
  endtask

  task automatic compare_all();
    chk("R3 act_prof", 32'(act_prof), 32'(m_sel));
    chk("R3 ftw", ftw, m_ftw[m_sel]);
    chk("R5 spec_inv", 32'(inv), 32'(mode == 2'd0 ? m_inv[m_sel] : 1'b0));
    chk("R2 icic_byp", 32'(icb), 32'(m_icb[m_sel]));
    chk("R6 cic_rate", 32'(rate), 32'(m_rate[m_sel]));
    chk("R6 cic_byp", 32'(cbyp), 32'(m_rate[m_sel] == 0));
    chk("R7 scale", 32'(scale), 32'(m_scale[m_sel]));
    chk("R8 phase", phase, m_phase);
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [1:0] p, input logic [2:0] f, input logic [31:0] d);
    wr_en = 1; wr_prof = p; wr_field = f; wr_data = d;
    step();
    wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 phase", phase, 32'd0);
    chk("R1 act_prof", 32'(act_prof), 32'd0);
    chk("R1 ftw", ftw, 32'd0);
    chk("R1 scale", 32'(scale), 32'd0);
    chk("R1 cic_byp", 32'(cbyp), 32'd1);
    compare_all();

    mode = 2'd1; sel = 2'd0;
    wr(2'd1, 3'd0, 32'h2000_0000);
    chk("R2 other profile untouched", ftw, 32'd0);
    wr(2'd2, 3'd0, 32'h0100_0000);
    wr(2'd3, 3'd0, 32'hF000_0001);
    wr(2'd3, 3'd1, 32'd3);
    wr(2'd3, 3'd2, 32'd63);
    wr(2'd3, 3'd3, 32'h0000_00FF);
    chk("R9 phase parked", phase, 32'd0);

    sel = 2'd2;
    step();
    chk("R3 prof 2", 32'(act_prof), 32'd2);
    chk("R3 ftw 2", ftw, 32'h0100_0000);
    chk("R10 no add at capture edge", phase, 32'd0);
    step();
    chk("R10 new ftw applied", phase, 32'h0100_0000);
    repeat (3) step();
    chk("R8 accumulate", phase, 32'h0400_0000);

    mode = 2'd0; stb = 0; sel = 2'd3;
    repeat (3) step();
    chk("R4 held without strobe", 32'(act_prof), 32'd2);
    chk("R8 accumulate", phase, 32'h0700_0000);
    stb = 1;
    step();
    stb = 0;
    chk("R4 captured on strobe", 32'(act_prof), 32'd3);
    chk("R10 phase kept", phase, 32'h0800_0000);
    chk("R5 invert in quad", 32'(inv), 32'd1);
    chk("R6 rate 63", 32'(rate), 32'd63);
    chk("R6 no bypass", 32'(cbyp), 32'd0);
    chk("R7 scale top code", 32'(scale), 32'hFF);

    mode = 2'd2;
    step();
    chk("R5 invert gated in dac mode", 32'(inv), 32'd0);
    mode = 2'd3;
    step();
    chk("R5 invert gated in mode 3", 32'(inv), 32'd0);
    repeat (4) step();  // R8 wraps with large ftw

    wr(2'd3, 3'd2, 32'd0);
    chk("R6 bypass code", 32'(cbyp), 32'd1);
    chk("R6 rate zero", 32'(rate), 32'd0);
    wr(2'd3, 3'd1, 32'd1);
    wr(2'd3, 3'd2, 32'd1);
    chk("R6 rate 1", 32'(rate), 32'd1);

    wr(2'd3, 3'd6, 32'hFFFF_FFFF);
    chk("R11 ftw unchanged", ftw, 32'hF000_0001);
    chk("R11 scale unchanged", 32'(scale), 32'hFF);
    chk("R11 rate unchanged", 32'(rate), 32'd1);
    wr(2'd3, 3'd4, 32'h0);
    chk("R11 flags unchanged", 32'(icb), 32'd0);

    wr(2'd3, 3'd0, 32'd0);
    chk("R9 ftw zero", ftw, 32'd0);
    step();
    chk("R9 zero phase", phase, 32'd0);

    for (int i = 0; i < 600; i++) begin
      wr_en = ($urandom % 3) == 0;
      wr_prof = 2'($urandom);
      wr_field = 3'($urandom);
      wr_data = ($urandom % 5 == 0) ? 32'd0 : $urandom;
      sel = 2'($urandom);
      mode = 2'($urandom);
      stb = ($urandom % 4) == 0;
      step();
    end
    wr_en = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule